// File: doc/BRIEF.md
# Paged External Data Memory Port

This block is the on-chip data RAM port of a small 8-bit controller. A requester issues single-byte reads and writes through a valid/ready handshake. Each request selects one of two addressing modes. In wide mode the request supplies the full 16-bit address. In paged mode the request supplies only the low byte. The high byte then comes from a page register, so each page covers 256 bytes.

A 3072-byte general RAM is folded across the whole 64 KB space. Only the low twelve address bits are decoded. A 12-bit offset at or above 3072 wraps back to the bottom of the RAM, so a linear fill never has to reset its pointer.

A separate 1 KB window RAM sits at offsets 0xC00 to 0xFFF. It can be reached only after an enable register has been set, and each access to it costs extra wait cycles. Both control registers sit on a small special-function register (SFR) bus with an 8-bit address.

Top module: `xdm_port`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid is 0. Reads of SFR addresses 0xAA and 0xAB both return 0x00.
- R2: SFR address 0xAA holds the page register. Bits [4:0] can be written and read back. Bits [7:5] always read as 0, and writing them has no effect.
- R3: SFR address 0xAB holds the window enable in bit 0, which can be written and read back. Bits [7:1] always read as 0.
- R4: In paged mode (req_paged=1), the effective address is {page register, req_addr[7:0]}. req_addr[15:8] is ignored.
- R5: With the enable clear, effective-address bits [15:12] are ignored. A 12-bit offset of 0xC00 or above reaches general-RAM location offset−0xC00. The window RAM is never touched.
- R6: With the enable set, offsets 0xC00–0xFFF reach the window RAM at index offset−0xC00. This storage is separate from general-RAM locations 0x000–0x3FF. Offsets below 0xC00 still reach the general RAM.
- R7: A general-RAM request is accepted on a rising edge where req_valid and req_ready are both 1. rsp_valid is then 1 for exactly the next cycle, with read data on rsp_rdata. req_ready stays 1.
- R8: A window request drives req_ready low for the three cycles after acceptance. No other request is accepted during those cycles. rsp_valid is 1 in the fourth cycle, which is also when req_ready returns to 1.
- R9: An access uses the page and enable values held at its acceptance edge. An SFR write on that same edge, or during a window wait, does not redirect the access.
- R10: SFR writes to any address other than 0xAA and 0xAB leave both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR address for reads and writes |
| sfr_wr_en | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, combinational from sfr_addr |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Port can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_paged | input | 1 | 1 = paged mode, 0 = wide mode |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid while rsp_valid is 1 on a read |

## Verification
The bench targets the fold boundary at 0xC00 under both enable settings. A decoder that ignored the enable would hide general-RAM bytes behind the window. A decoder that masked address bits instead of subtracting 0xC00 would return the wrong aliased byte. It also measures stall length and response timing on window accesses, where an off-by-one counter shows up as two or four stall cycles. The same-edge page write and the enable being dropped mid-wait expose a design that decodes late, because such a design writes to the newly selected page or RAM. The read-only page bits and writes to unrelated SFR addresses catch register decode that is too loose.

// File: rtl/xdm_pkg.sv
package xdm_pkg;
   localparam int unsigned XDM_DATA_W = 8;
   localparam int unsigned XDM_ADDR_W = 16;

   typedef enum logic {
      XDM_TGT_GP   = 1'b0,
      XDM_TGT_WIN  = 1'b1
   } xdm_tgt_e;

   typedef logic [XDM_DATA_W-1:0] xdm_byte_t;
   typedef logic [XDM_ADDR_W-1:0] xdm_addr_t;
endpackage

// File: rtl/xdm_sfr_regs.sv
module xdm_sfr_regs
   import xdm_pkg::*;
#(
   parameter int unsigned PAGE_BITS = 5,
   parameter logic [7:0]  PAGE_SFR  = 8'hAA,
   parameter logic [7:0]  WEN_SFR   = 8'hAB
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic [7:0] sfr_addr,
   input  logic      sfr_wr_en,
   input  xdm_byte_t sfr_wdata,
   output xdm_byte_t sfr_rdata,
   output xdm_byte_t page_o,
   output logic      wen_o
);
   if (PAGE_BITS < 1 || PAGE_BITS > 8) begin : g_bad_page
      $error("xdm_sfr_regs: PAGE_BITS must be 1..8");
   end
   if (PAGE_SFR == WEN_SFR) begin : g_bad_addr
      $error("xdm_sfr_regs: register addresses must differ");
   end

   logic [PAGE_BITS-1:0] page_q;
   logic                 wen_q;
   logic                 unused_wd;

   assign unused_wd = ^sfr_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         wen_q  <= 1'b0;
      end else if (sfr_wr_en) begin
         if (sfr_addr == PAGE_SFR) page_q <= sfr_wdata[PAGE_BITS-1:0];
         if (sfr_addr == WEN_SFR)  wen_q  <= sfr_wdata[0];
      end
   end

   if (PAGE_BITS < 8) begin : g_page_pad
      assign page_o = {{(8-PAGE_BITS){1'b0}}, page_q};
   end else begin : g_page_full
      assign page_o = page_q;
   end
   assign wen_o = wen_q;

   always_comb begin
      sfr_rdata = '0;
      if (sfr_addr == PAGE_SFR) sfr_rdata = page_o;
      else if (sfr_addr == WEN_SFR) sfr_rdata = {7'd0, wen_q};
   end

   // R2: a page write lands, with only the writable field kept
   a_r2_page_write: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_wr_en && sfr_addr == PAGE_SFR) |=>
         (page_o == {{(8-PAGE_BITS){1'b0}}, $past(sfr_wdata[PAGE_BITS-1:0])}));
   // R10: writes elsewhere leave both registers alone
   a_r10_other_sfr: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_wr_en && sfr_addr != PAGE_SFR && sfr_addr != WEN_SFR) |=>
         ($stable(page_o) && $stable(wen_o)));
   // R3: enable read-back exposes a single bit
   a_r3_wen_read: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_addr == WEN_SFR) |-> (sfr_rdata[7:1] == 7'd0));
endmodule

// File: rtl/xdm_addr_decode.sv
module xdm_addr_decode
   import xdm_pkg::*;
#(
   parameter int unsigned GP_BYTES  = 3072,
   parameter int unsigned WIN_BYTES = 1024,
   parameter int unsigned DEC_BITS  = 12,
   localparam int unsigned GP_AW    = $clog2(GP_BYTES),
   localparam int unsigned WIN_AW   = $clog2(WIN_BYTES)
) (
   input  xdm_addr_t          req_addr,
   input  logic               req_paged,
   input  xdm_byte_t          page,
   input  logic               wen,
   output logic [GP_AW-1:0]   gp_idx,
   output logic [WIN_AW-1:0]  win_idx,
   output xdm_tgt_e           tgt
);
   localparam logic [DEC_BITS-1:0] GP_LIM = DEC_BITS'(GP_BYTES);

   if (DEC_BITS > XDM_ADDR_W) begin : g_bad_dec
      $error("xdm_addr_decode: DEC_BITS wider than the address");
   end
   if (GP_BYTES >= (1 << DEC_BITS) || (1 << DEC_BITS) > 2 * GP_BYTES) begin : g_bad_fold
      $error("xdm_addr_decode: fold needs GP_BYTES < 2**DEC_BITS <= 2*GP_BYTES");
   end
   if (WIN_BYTES < (1 << DEC_BITS) - GP_BYTES) begin : g_bad_win
      $error("xdm_addr_decode: window smaller than the folded range");
   end

   xdm_addr_t           eff;
   logic [DEC_BITS-1:0] off;
   logic [DEC_BITS-1:0] above;
   logic                over;
   logic                unused_hi;

   always_comb begin
      eff   = req_paged ? {page, req_addr[7:0]} : req_addr;
      off   = eff[DEC_BITS-1:0];
      over  = (off >= GP_LIM);
      above = off - GP_LIM;
      gp_idx  = GP_AW'(over ? above : off);
      win_idx = WIN_AW'(above);
      tgt     = (wen && over) ? XDM_TGT_WIN : XDM_TGT_GP;
   end

   assign unused_hi = ^eff;
endmodule

// File: rtl/xdm_spram.sv
module xdm_spram
   import xdm_pkg::*;
#(
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  xdm_byte_t     wdata,
   output xdm_byte_t     rdata
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("xdm_spram: DEPTH must be at least 2");
   end

   xdm_byte_t mem [DEPTH];
   xdm_byte_t rd_q;

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         else    rd_q      <= mem[addr];
      end
   end

   assign rdata = rd_q;
endmodule

// File: rtl/xdm_port.sv
module xdm_port
   import xdm_pkg::*;
#(
   parameter int unsigned GP_BYTES  = 3072,
   parameter int unsigned WIN_BYTES = 1024,
   parameter int unsigned DEC_BITS  = 12,
   parameter int unsigned PAGE_BITS = 5,
   parameter int unsigned WIN_WAIT  = 3,
   parameter logic [7:0]  PAGE_SFR  = 8'hAA,
   parameter logic [7:0]  WEN_SFR   = 8'hAB
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  sfr_addr,
   input  logic        sfr_wr_en,
   input  logic [7:0]  sfr_wdata,
   output logic [7:0]  sfr_rdata,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic        req_write,
   input  logic        req_paged,
   input  logic [15:0] req_addr,
   input  logic [7:0]  req_wdata,
   output logic        rsp_valid,
   output logic [7:0]  rsp_rdata
);
   localparam int unsigned GP_AW  = $clog2(GP_BYTES);
   localparam int unsigned WIN_AW = $clog2(WIN_BYTES);
   localparam int unsigned CNT_W  = (WIN_WAIT > 1) ? $clog2(WIN_WAIT) : 1;

   xdm_byte_t          page;
   logic               wen;
   logic [GP_AW-1:0]   gp_idx;
   logic [WIN_AW-1:0]  win_idx;
   xdm_tgt_e           tgt;
   logic               accept;
   logic               hit_win;
   logic               busy;
   logic               win_en, win_we;
   logic [WIN_AW-1:0]  win_addr;
   xdm_byte_t          win_wd;
   xdm_byte_t          gp_rd, win_rd;
   logic               rsp_q;
   xdm_tgt_e           rsp_src_q;

   xdm_sfr_regs #(
      .PAGE_BITS (PAGE_BITS),
      .PAGE_SFR  (PAGE_SFR),
      .WEN_SFR   (WEN_SFR)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sfr_addr  (sfr_addr),
      .sfr_wr_en (sfr_wr_en),
      .sfr_wdata (sfr_wdata),
      .sfr_rdata (sfr_rdata),
      .page_o    (page),
      .wen_o     (wen)
   );

   xdm_addr_decode #(
      .GP_BYTES  (GP_BYTES),
      .WIN_BYTES (WIN_BYTES),
      .DEC_BITS  (DEC_BITS)
   ) dec_i (
      .req_addr  (req_addr),
      .req_paged (req_paged),
      .page      (page),
      .wen       (wen),
      .gp_idx    (gp_idx),
      .win_idx   (win_idx),
      .tgt       (tgt)
   );

   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;
   assign hit_win   = (tgt == XDM_TGT_WIN);

   xdm_spram #(.DEPTH(GP_BYTES)) gp_ram_i (
      .clk   (clk),
      .en    (accept && !hit_win),
      .we    (req_write),
      .addr  (gp_idx),
      .wdata (req_wdata),
      .rdata (gp_rd)
   );

   if (WIN_WAIT == 0) begin : g_win_direct
      assign busy     = 1'b0;
      assign win_en   = accept && hit_win;
      assign win_we   = req_write;
      assign win_addr = win_idx;
      assign win_wd   = req_wdata;
   end else begin : g_win_wait
      logic              busy_q;
      logic [CNT_W-1:0]  cnt_q;
      logic              hold_we;
      logic [WIN_AW-1:0] hold_addr;
      xdm_byte_t         hold_wd;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            hold_we   <= 1'b0;
            hold_addr <= '0;
            hold_wd   <= '0;
         end else if (busy_q) begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            else             busy_q <= 1'b0;
         end else if (accept && hit_win) begin
            busy_q    <= 1'b1;
            cnt_q     <= CNT_W'(WIN_WAIT - 1);
            hold_we   <= req_write;
            hold_addr <= win_idx;
            hold_wd   <= req_wdata;
         end
      end

      assign busy     = busy_q;
      assign win_en   = busy_q && (cnt_q == '0);
      assign win_we   = hold_we;
      assign win_addr = hold_addr;
      assign win_wd   = hold_wd;

      // R8: a window acceptance stalls the port and withholds the response
      a_r8_win_stall: assert property (@(posedge clk) disable iff (!rst_n)
         (accept && hit_win) |=> (!req_ready && !rsp_valid));
      // R8: the port reopens exactly when the window access responds
      a_r8_reopen_rsp: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(req_ready) |-> rsp_valid);
   end

   xdm_spram #(.DEPTH(WIN_BYTES)) win_ram_i (
      .clk   (clk),
      .en    (win_en),
      .we    (win_we),
      .addr  (win_addr),
      .wdata (win_wd),
      .rdata (win_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_q     <= 1'b0;
         rsp_src_q <= XDM_TGT_GP;
      end else begin
         rsp_q     <= (accept && !hit_win) || win_en;
         rsp_src_q <= win_en ? XDM_TGT_WIN : XDM_TGT_GP;
      end
   end

   assign rsp_valid = rsp_q;
   assign rsp_rdata = (rsp_src_q == XDM_TGT_WIN) ? win_rd : gp_rd;

   // R7: general-RAM access answers next cycle and keeps the port open
   a_r7_gp_next: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !hit_win) |=> (rsp_valid && req_ready));
   // R5: window never selected while the enable is clear
   a_r5_no_win_off: assert property (@(posedge clk) disable iff (!rst_n)
      !wen |-> !hit_win);
   // R5: folded general index always inside the array
   a_r5_gp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !hit_win) |-> (int'(gp_idx) < GP_BYTES));
endmodule

// File: tb/xdm_port_tb.sv
module xdm_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  sfr_addr = '0;
   logic        sfr_wr_en = 1'b0;
   logic [7:0]  sfr_wdata = '0;
   logic [7:0]  sfr_rdata;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic        req_paged = 1'b0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_valid;
   logic [7:0]  rsp_rdata;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   xdm_port dut_i (
      .clk(clk), .rst_n(rst_n),
      .sfr_addr(sfr_addr), .sfr_wr_en(sfr_wr_en), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_paged(req_paged),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      sfr_addr = a; sfr_wdata = d; sfr_wr_en = 1'b1;
      @(posedge clk); #1;
      sfr_wr_en = 1'b0;
   endtask

   task automatic sfr_rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      sfr_addr = a;
      #1 d = sfr_rdata;
   endtask

   task automatic wait_rsp(output logic [7:0] rd, output int lat, output int stall);
      lat = 0; stall = 0;
      do begin
         @(negedge clk);
         lat++;
         if (!req_ready) stall++;
      end while (!rsp_valid && lat < 20);
      rd = rsp_rdata;
   endtask

   task automatic mem_op(input bit wr, input logic [15:0] a, input bit pg, input logic [7:0] wd,
                         output logic [7:0] rd, output int lat, output int stall);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_paged = pg; req_wdata = wd;
      while (!req_ready) @(negedge clk);
      @(posedge clk); #1;
      req_valid = 1'b0;
      wait_rsp(rd, lat, stall);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1 ready", {31'd0, req_ready}, 32'd1);
      chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
      sfr_rd(8'hAA, v); chk("R1 page reset", {24'd0, v}, 32'h00);
      sfr_rd(8'hAB, v); chk("R1 enable reset", {24'd0, v}, 32'h00);
   endtask

   task automatic t_sfr();
      logic [7:0] v;
      sfr_wr(8'hAA, 8'hFF); sfr_rd(8'hAA, v); chk("R2 page field masks", {24'd0, v}, 32'h1F);
      sfr_wr(8'hAA, 8'hE6); sfr_rd(8'hAA, v); chk("R2 page field", {24'd0, v}, 32'h06);
      sfr_wr(8'hAB, 8'hFF); sfr_rd(8'hAB, v); chk("R3 enable bit", {24'd0, v}, 32'h01);
      sfr_wr(8'h30, 8'h00); sfr_wr(8'hA9, 8'h00);
      sfr_rd(8'hAA, v); chk("R10 page kept", {24'd0, v}, 32'h06);
      sfr_rd(8'hAB, v); chk("R10 enable kept", {24'd0, v}, 32'h01);
      sfr_wr(8'hAB, 8'hFE); sfr_rd(8'hAB, v); chk("R3 enable clear", {24'd0, v}, 32'h00);
      sfr_wr(8'hAA, 8'h00);
   endtask

   task automatic t_paged();
      logic [7:0] rd; int lat, st;
      sfr_wr(8'hAA, 8'h01);
      mem_op(1, 16'hEE34, 1, 8'h5A, rd, lat, st);
      mem_op(0, 16'h0134, 0, 8'h00, rd, lat, st);
      chk("R4 page 1 lands at 0x0134", {24'd0, rd}, 32'h5A);
      sfr_wr(8'hAA, 8'h0B);
      mem_op(1, 16'h00FF, 1, 8'hC3, rd, lat, st);
      mem_op(0, 16'h0BFF, 0, 8'h00, rd, lat, st);
      chk("R4 page 0x0B top byte", {24'd0, rd}, 32'hC3);
      mem_op(0, 16'h77FF, 1, 8'h00, rd, lat, st);
      chk("R4 paged read ignores high byte", {24'd0, rd}, 32'hC3);
   endtask

   task automatic t_fold();
      logic [7:0] rd; int lat, st;
      mem_op(1, 16'h0010, 0, 8'h11, rd, lat, st);
      chk("R7 write latency", lat, 1);
      mem_op(0, 16'h4010, 0, 8'h00, rd, lat, st);
      chk("R5 bits 15:12 ignored", {24'd0, rd}, 32'h11);
      chk("R7 read latency", lat, 1);
      chk("R7 no stall", st, 0);
      mem_op(0, 16'h0C10, 0, 8'h00, rd, lat, st);
      chk("R5 0xC10 folds to 0x010", {24'd0, rd}, 32'h11);
      mem_op(1, 16'hAFFF, 0, 8'h6E, rd, lat, st);
      mem_op(0, 16'h03FF, 0, 8'h00, rd, lat, st);
      chk("R5 0xFFF folds to 0x3FF", {24'd0, rd}, 32'h6E);
      mem_op(1, 16'h0BFF, 0, 8'h29, rd, lat, st);
      mem_op(0, 16'h1BFF, 0, 8'h00, rd, lat, st);
      chk("R5 0xBFF stays unfolded", {24'd0, rd}, 32'h29);
   endtask

   task automatic t_window();
      logic [7:0] rd; int lat, st;
      sfr_wr(8'hAB, 8'h01);
      mem_op(1, 16'h0C10, 0, 8'hA5, rd, lat, st);
      chk("R8 window write latency", lat, 4);
      chk("R8 window stall cycles", st, 3);
      mem_op(0, 16'hFC10, 0, 8'h00, rd, lat, st);
      chk("R6 window read back", {24'd0, rd}, 32'hA5);
      chk("R8 window read latency", lat, 4);
      mem_op(0, 16'h0010, 0, 8'h00, rd, lat, st);
      chk("R6 general RAM kept apart", {24'd0, rd}, 32'h11);
      chk("R6 general latency with enable", lat, 1);
      mem_op(0, 16'h0BFF, 0, 8'h00, rd, lat, st);
      chk("R6 below 0xC00 stays general", {24'd0, rd}, 32'h29);
      sfr_wr(8'hAB, 8'h00);
      mem_op(0, 16'h0C10, 0, 8'h00, rd, lat, st);
      chk("R5 enable off hides window", {24'd0, rd}, 32'h11);
   endtask

   task automatic t_same_edge();
      logic [7:0] rd; int lat, st;
      mem_op(1, 16'h0340, 0, 8'h00, rd, lat, st);
      sfr_wr(8'hAA, 8'h02);
      @(negedge clk);
      sfr_addr = 8'hAA; sfr_wdata = 8'h03; sfr_wr_en = 1'b1;
      req_valid = 1'b1; req_write = 1'b1; req_paged = 1'b1; req_addr = 16'h0040; req_wdata = 8'h9C;
      @(posedge clk); #1;
      sfr_wr_en = 1'b0; req_valid = 1'b0;
      wait_rsp(rd, lat, st);
      mem_op(0, 16'h0240, 0, 8'h00, rd, lat, st);
      chk("R9 same-edge write uses old page", {24'd0, rd}, 32'h9C);
      mem_op(0, 16'h0340, 0, 8'h00, rd, lat, st);
      chk("R9 new page untouched", {24'd0, rd}, 32'h00);
   endtask

   task automatic t_hold();
      logic [7:0] rd; int lat, st;
      mem_op(1, 16'h0020, 0, 8'h44, rd, lat, st);
      sfr_wr(8'hAB, 8'h01);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_paged = 1'b0; req_addr = 16'h0C20; req_wdata = 8'h3C;
      @(posedge clk); #1;
      req_valid = 1'b0;
      sfr_addr = 8'hAB; sfr_wdata = 8'h00; sfr_wr_en = 1'b1;
      @(posedge clk); #1;
      sfr_wr_en = 1'b0;
      wait_rsp(rd, lat, st);
      chk("R8 in-flight completes", {31'd0, rsp_valid}, 32'd1);
      mem_op(0, 16'h0020, 0, 8'h00, rd, lat, st);
      chk("R9 mid-wait disable keeps target", {24'd0, rd}, 32'h44);
      sfr_wr(8'hAB, 8'h01);
      mem_op(0, 16'h0C20, 0, 8'h00, rd, lat, st);
      chk("R9 window got in-flight data", {24'd0, rd}, 32'h3C);
      sfr_wr(8'hAB, 8'h00);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sfr();
      t_paged();
      t_fold();
      t_window();
      t_same_edge();
      t_hold();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule